// File: doc/BRIEF.md
# Paged Local-to-Global Address Translator

This block turns a 16-bit processor address into a 23-bit address in a larger global memory space. Several windows of the 64K local space show a selectable page of a bigger resource: a 1K nonvolatile-data window, a 4K RAM window and a 16K program-flash window. Each window splices its own page register into the output. The remaining local regions are wired to fixed pages. The 0x4000–0x7FFF region can be pointed at flash, RAM or external space by a two-bit mode input.

A separate path serves global-instruction accesses. When `glob_acc` is high, all window decoding is skipped and the output is the 7-bit global page followed by the full local address. Every output is combinational from the inputs and the four page registers. The page registers are written through a small strobe, select and data port and can be read back. A three-bit resource code tells the memory fabric which resource the access falls in.

Top module: `paged_addr_xlate`

## Requirements
- R1: After reset the page registers read back (pg_sel 0 = RAM, 1 = EEPROM, 2 = flash, 3 = global) as 0xFD, 0xFE, 0xFE and 0x7F; `pg_rdata` always shows the register chosen by `pg_sel`.
- R2: Local 0x0000–0x07FF gives the same value zero-extended, with resource code 0 (registers).
- R3: Local 0x0800–0x0BFF gives 0x100000 + EEPROM page × 0x400 + the address offset within the window, with resource code 1 (EEPROM).
- R4: Local 0x0C00–0x0FFF gives EEPROM page 0xFF, which is 0x13FC00 + the offset, with resource code 1.
- R5: Local 0x1000–0x1FFF gives RAM page × 0x1000 + local bits [11:0], with resource code 2 (RAM).
- R6: Local 0x2000–0x3FFF gives RAM pages 0xFE then 0xFF, which is 0x0FE000 + the offset, with resource code 2.
- R7: Local 0x8000–0xBFFF gives 0x400000 + flash page × 0x4000 + local bits [13:0], with resource code 3 (flash).
- R8: Local 0xC000–0xFFFF gives flash page 0xFF, which is 0x7FC000 + the offset, with resource code 3.
- R9: For local 0x4000–0x7FFF the mode input selects the target. Mode 1 gives 0x0FC000 + offset with code 2. Mode 2 gives 0x144000 + offset with code 4 (external). Modes 0 and 3 give 0x7F4000 + offset with code 3.
- R10: With `glob_acc` high, the output is global page × 0x10000 + the local address, whatever the window and the mode.
- R11: A write to a page register takes effect from the next cycle. An access in the write cycle uses the old page. The global page keeps only data bits [6:0], and bit 7 reads as 0.
- R12: On the global path the resource code follows the global area. Below 0x000800 gives 0, below 0x100000 gives 2, below 0x140000 gives 1, below 0x400000 gives 4, and the rest gives 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_addr | input | 16 | Local address from the processor |
| glob_acc | input | 1 | Access comes from a global instruction |
| win_mode | input | 2 | Target of the 0x4000–0x7FFF region |
| pg_we | input | 1 | Page register write strobe |
| pg_sel | input | 2 | Page register select for write and read |
| pg_wdata | input | 8 | Page register write data |
| pg_rdata | output | 8 | Selected page register value |
| glob_addr | output | 23 | Translated global address |
| res_sel | output | 3 | Resource code |

## Verification
A page register write and a translation through the window that uses it can fall in the same cycle. The same is true of a global-page write and a global-instruction access. The bench provokes both on purpose: it holds the address inside the window while the strobe is high. It then expects the old page in that cycle and the new page one cycle later. A behavioural model, clocked like the register file, judges every cycle of the directed and random phases.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int LA_W  = 16;
    localparam int GA_W  = 23;
    localparam int PG_W  = 8;
    localparam int GP_W  = 7;
    localparam int N_PG  = 4;
    localparam int SEL_W = $clog2(N_PG);

    typedef enum logic [2:0] {
        RES_REG   = 3'd0,
        RES_EE    = 3'd1,
        RES_RAM   = 3'd2,
        RES_FLASH = 3'd3,
        RES_EXT   = 3'd4
    } res_e;

    typedef enum logic [1:0] {
        PG_RAM = 2'd0,
        PG_EE  = 2'd1,
        PG_FL  = 2'd2,
        PG_GLB = 2'd3
    } pgsel_e;

    typedef enum logic [1:0] {
        MID_FLASH = 2'd0,
        MID_RAM   = 2'd1,
        MID_EXT   = 2'd2,
        MID_ALT   = 2'd3
    } mid_e;

    typedef struct packed {
        logic [GA_W-1:0] addr;
        res_e            res;
    } xlate_t;

    localparam logic [GA_W-1:0] AREA_RAM_LO = 23'h000800;
    localparam logic [GA_W-1:0] AREA_EE_LO  = 23'h100000;
    localparam logic [GA_W-1:0] AREA_EXT_LO = 23'h140000;
    localparam logic [GA_W-1:0] AREA_FL_LO  = 23'h400000;

    function automatic logic [PG_W-1:0] reset_page(input int idx);
        case (idx)
            0:       return 8'hFD;
            1:       return 8'hFE;
            2:       return 8'hFE;
            default: return 8'h7F;
        endcase
    endfunction

    function automatic logic [PG_W-1:0] store_mask(input int idx);
        return (idx == int'(PG_GLB)) ? {1'b0, {GP_W{1'b1}}} : {PG_W{1'b1}};
    endfunction

    function automatic res_e area_of(input logic [GA_W-1:0] ga);
        if (ga < AREA_RAM_LO)      return RES_REG;
        else if (ga < AREA_EE_LO)  return RES_RAM;
        else if (ga < AREA_EXT_LO) return RES_EE;
        else if (ga < AREA_FL_LO)  return RES_EXT;
        else                       return RES_FLASH;
    endfunction
endpackage

// File: rtl/xlate_page_regs.sv
module xlate_page_regs
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [PG_W-1:0]  wdata,
    output logic [PG_W-1:0]  ram_pg,
    output logic [PG_W-1:0]  ee_pg,
    output logic [PG_W-1:0]  fl_pg,
    output logic [GP_W-1:0]  glb_pg,
    output logic [PG_W-1:0]  rdata
);
    logic [PG_W-1:0] pg_q [N_PG];

    for (genvar i = 0; i < N_PG; i++) begin : g_pg
        always_ff @(posedge clk) begin
            if (rst)
                pg_q[i] <= reset_page(i);
            else if (we && sel == SEL_W'(i))
                pg_q[i] <= wdata & store_mask(i);
        end
    end

    assign ram_pg = pg_q[PG_RAM];
    assign ee_pg  = pg_q[PG_EE];
    assign fl_pg  = pg_q[PG_FL];
    assign glb_pg = pg_q[PG_GLB][GP_W-1:0];
    assign rdata  = pg_q[sel];
endmodule

// File: rtl/xlate_local_dec.sv
module xlate_local_dec
    import xlate_pkg::*;
(
    input  logic [LA_W-1:0] la,
    input  mid_e            mode,
    input  logic [PG_W-1:0] ram_pg,
    input  logic [PG_W-1:0] ee_pg,
    input  logic [PG_W-1:0] fl_pg,
    output xlate_t          xo
);
    localparam logic [PG_W-1:0] EE_FIX_PG  = 8'hFF;
    localparam logic [PG_W-1:0] FL_TOP_PG  = 8'hFF;
    localparam logic [PG_W-1:0] FL_MID_PG  = 8'hFD;
    localparam logic [4:0]      EE_BASE    = 5'b00100;
    localparam logic [8:0]      EXT_MID    = 9'h051;

    always_comb begin
        xo.addr = {{(GA_W-LA_W){1'b0}}, la};
        xo.res  = RES_REG;
        if (la[15:14] == 2'b11) begin
            xo.addr = {1'b1, FL_TOP_PG, la[13:0]};
            xo.res  = RES_FLASH;
        end else if (la[15:14] == 2'b10) begin
            xo.addr = {1'b1, fl_pg, la[13:0]};
            xo.res  = RES_FLASH;
        end else if (la[15:14] == 2'b01) begin
            case (mode)
                MID_RAM: begin
                    xo.addr = {3'b000, 6'h3F, la[13:0]};
                    xo.res  = RES_RAM;
                end
                MID_EXT: begin
                    xo.addr = {EXT_MID, la[13:0]};
                    xo.res  = RES_EXT;
                end
                default: begin
                    xo.addr = {1'b1, FL_MID_PG, la[13:0]};
                    xo.res  = RES_FLASH;
                end
            endcase
        end else if (la[13]) begin
            xo.addr = {3'b000, 7'h7F, la[12:0]};
            xo.res  = RES_RAM;
        end else if (la[12]) begin
            xo.addr = {3'b000, ram_pg, la[11:0]};
            xo.res  = RES_RAM;
        end else if (la[11:10] == 2'b11) begin
            xo.addr = {EE_BASE, EE_FIX_PG, la[9:0]};
            xo.res  = RES_EE;
        end else if (la[11]) begin
            xo.addr = {EE_BASE, ee_pg, la[9:0]};
            xo.res  = RES_EE;
        end
    end
endmodule

// File: rtl/xlate_glob_path.sv
module xlate_glob_path
    import xlate_pkg::*;
(
    input  logic [LA_W-1:0] la,
    input  logic [GP_W-1:0] glb_pg,
    output xlate_t          xo
);
    always_comb begin
        xo.addr = {glb_pg, la};
        xo.res  = area_of(xo.addr);
    end
endmodule

// File: rtl/paged_addr_xlate.sv
module paged_addr_xlate
    import xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] loc_addr,
    input  logic        glob_acc,
    input  logic [1:0]  win_mode,
    input  logic        pg_we,
    input  logic [1:0]  pg_sel,
    input  logic [7:0]  pg_wdata,
    output logic [7:0]  pg_rdata,
    output logic [22:0] glob_addr,
    output logic [2:0]  res_sel
);
    logic [PG_W-1:0] ram_pg, ee_pg, fl_pg;
    logic [GP_W-1:0] glb_pg;
    xlate_t          loc_x, glb_x, sel_x;

    xlate_page_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (pg_we),
        .sel    (pg_sel),
        .wdata  (pg_wdata),
        .ram_pg (ram_pg),
        .ee_pg  (ee_pg),
        .fl_pg  (fl_pg),
        .glb_pg (glb_pg),
        .rdata  (pg_rdata)
    );

    xlate_local_dec u_loc (
        .la     (loc_addr),
        .mode   (mid_e'(win_mode)),
        .ram_pg (ram_pg),
        .ee_pg  (ee_pg),
        .fl_pg  (fl_pg),
        .xo     (loc_x)
    );

    xlate_glob_path u_glb (
        .la     (loc_addr),
        .glb_pg (glb_pg),
        .xo     (glb_x)
    );

    assign sel_x     = glob_acc ? glb_x : loc_x;
    assign glob_addr = sel_x.addr;
    assign res_sel   = sel_x.res;
endmodule

// File: rtl/paged_addr_xlate_chk.sv
module paged_addr_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] loc_addr,
    input logic        glob_acc,
    input logic [1:0]  win_mode,
    input logic        pg_we,
    input logic [1:0]  pg_sel,
    input logic [7:0]  pg_wdata,
    input logic [7:0]  pg_rdata,
    input logic [22:0] glob_addr,
    input logic [2:0]  res_sel
);
    assert_regspace_R2: assert property (@(posedge clk) disable iff (rst)
        (!glob_acc && loc_addr < 16'h0800) |-> (glob_addr == {7'd0, loc_addr} && res_sel == 3'd0));

    assert_top_flash_R8: assert property (@(posedge clk) disable iff (rst)
        (!glob_acc && loc_addr[15:14] == 2'b11) |-> (glob_addr[22:14] == 9'h1FF && res_sel == 3'd3));

    assert_mid_ext_R9: assert property (@(posedge clk) disable iff (rst)
        (!glob_acc && loc_addr[15:14] == 2'b01 && win_mode == 2'd2) |-> (glob_addr[22:14] == 9'h051 && res_sel == 3'd4));

    assert_glob_low_R10: assert property (@(posedge clk) disable iff (rst)
        glob_acc |-> (glob_addr[15:0] == loc_addr));

    assert_gpage_bit7_R11: assert property (@(posedge clk) disable iff (rst)
        (pg_sel == 2'd3) |-> !pg_rdata[7]);

    assert_ram_write_R11: assert property (@(posedge clk) disable iff (rst)
        (pg_we && pg_sel == 2'd0) |=>
        (glob_acc || loc_addr[15:12] != 4'h1 || glob_addr[19:12] == $past(pg_wdata)));

    assert_glob_area_R12: assert property (@(posedge clk) disable iff (rst)
        (glob_acc && glob_addr >= 23'h400000) |-> res_sel == 3'd3);
endmodule

bind paged_addr_xlate paged_addr_xlate_chk u_chk (.*);

// File: tb/paged_addr_xlate_test.sv
module paged_addr_xlate_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] loc_addr = 0;
    logic        glob_acc = 0;
    logic [1:0]  win_mode = 0;
    logic        pg_we = 0;
    logic [1:0]  pg_sel = 0;
    logic [7:0]  pg_wdata = 0;
    logic [7:0]  pg_rdata;
    logic [22:0] glob_addr;
    logic [2:0]  res_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit any_wr = 0;
    int m_pg [4];

    always #5 clk = ~clk;

    paged_addr_xlate uut (.*);

    // Behavioural reference: page registers
    always @(posedge clk) begin
        if (rst) begin
            m_pg[0] <= 'hFD; m_pg[1] <= 'hFE; m_pg[2] <= 'hFE; m_pg[3] <= 'h7F;
        end else if (pg_we) begin
            m_pg[pg_sel] <= (pg_sel == 3) ? (pg_wdata % 128) : pg_wdata;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int area(input int ga);
        if (ga < 'h800) return 0;
        if (ga < 'h100000) return 2;
        if (ga < 'h140000) return 1;
        if (ga < 'h400000) return 4;
        return 3;
    endfunction

    function automatic string tag(input int a, input bit g);
        if (g)            return "R10/R12";
        if (a < 'h0800)   return "R2";
        if (a < 'h0C00)   return "R3";
        if (a < 'h1000)   return "R4";
        if (a < 'h2000)   return "R5";
        if (a < 'h4000)   return "R6";
        if (a < 'h8000)   return "R9";
        if (a < 'hC000)   return "R7";
        return "R8";
    endfunction

    task automatic expect_xlate(input int a, input bit g, input int md,
                                output int ga, output int rs);
        if (g) begin
            ga = m_pg[3] * 65536 + a; rs = area(ga);
        end else if (a < 'h0800) begin
            ga = a; rs = 0;
        end else if (a < 'h0C00) begin
            ga = 'h100000 + m_pg[1] * 1024 + (a - 'h0800); rs = 1;
        end else if (a < 'h1000) begin
            ga = 'h100000 + 255 * 1024 + (a - 'h0C00); rs = 1;
        end else if (a < 'h2000) begin
            ga = m_pg[0] * 4096 + (a - 'h1000); rs = 2;
        end else if (a < 'h4000) begin
            ga = 'hFE * 4096 + (a - 'h2000); rs = 2;
        end else if (a < 'h8000) begin
            if (md == 1)      begin ga = 'h0FC000 + (a - 'h4000); rs = 2; end
            else if (md == 2) begin ga = 'h144000 + (a - 'h4000); rs = 4; end
            else              begin ga = 'h400000 + 'hFD * 16384 + (a - 'h4000); rs = 3; end
        end else if (a < 'hC000) begin
            ga = 'h400000 + m_pg[2] * 16384 + (a - 'h8000); rs = 3;
        end else begin
            ga = 'h400000 + 255 * 16384 + (a - 'hC000); rs = 3;
        end
    endtask

    // Drive on negedge, compare just before the next posedge
    task automatic step(input int a, input bit g, input int md,
                        input bit we, input int sel, input int wd);
        int ega, ers;
        @(negedge clk);
        loc_addr = a[15:0]; glob_acc = g; win_mode = md[1:0];
        pg_we = we; pg_sel = sel[1:0]; pg_wdata = wd[7:0];
        #4;
        expect_xlate(a, g, md, ega, ers);
        checks++;
        if (int'(glob_addr) != ega) begin
            fails++;
            $display("FAIL %s addr: local %h actual %h expected %h", tag(a, g), a, glob_addr, ega);
        end
        checks++;
        if (int'(res_sel) != ers) begin
            fails++;
            $display("FAIL %s res: local %h actual %0d expected %0d", tag(a, g), a, res_sel, ers);
        end
        checks++;
        if (int'(pg_rdata) != m_pg[sel]) begin
            fails++;
            $display("FAIL %s readback sel %0d: actual %h expected %h",
                     any_wr ? "R11" : "R1", sel, pg_rdata, m_pg[sel]);
        end
        if (we) any_wr = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values through readback
        for (int s = 0; s < 4; s++) step(0, 0, 0, 0, s, 0);
        // R2..R8 boundaries with reset pages
        step('h0000, 0, 0, 0, 0, 0); step('h07FF, 0, 0, 0, 0, 0);
        step('h0800, 0, 0, 0, 1, 0); step('h0BFF, 0, 0, 0, 1, 0);
        step('h0C00, 0, 0, 0, 0, 0); step('h0FFF, 0, 0, 0, 0, 0);
        step('h1000, 0, 0, 0, 0, 0); step('h1FFF, 0, 0, 0, 0, 0);
        step('h2000, 0, 0, 0, 0, 0); step('h3000, 0, 0, 0, 0, 0); step('h3FFF, 0, 0, 0, 0, 0);
        step('h8000, 0, 0, 0, 2, 0); step('hBFFF, 0, 0, 0, 2, 0);
        step('hC000, 0, 0, 0, 0, 0); step('hFFFF, 0, 0, 0, 0, 0);
        // R9: every mode at both ends of the mid region
        for (int md = 0; md < 4; md++) begin
            step('h4000, 0, md, 0, 0, 0);
            step('h7FFF, 0, md, 0, 0, 0);
        end
        // R11: write in same cycle as a window access, then the cycle after
        step('h1234, 0, 0, 1, 0, 'h3C);  step('h1234, 0, 0, 0, 0, 0);
        step('h0A55, 0, 0, 1, 1, 'h00);  step('h0A55, 0, 0, 0, 1, 0);
        step('h9ABC, 0, 0, 1, 2, 'hC1);  step('h9ABC, 0, 0, 0, 2, 0);
        // R10/R11: global page write keeps 7 bits, with a global access alongside
        step('h5678, 1, 0, 1, 3, 'hFF);  step('h5678, 1, 0, 0, 3, 0);
        step('h0100, 1, 2, 1, 3, 'h80);  step('h0100, 1, 2, 0, 3, 0);
        // R12: one access in every global area
        step('h0400, 1, 0, 1, 3, 'h10);  step('h0000, 1, 0, 0, 3, 0);
        step('h0000, 1, 0, 1, 3, 'h13);  step('hFFFF, 1, 0, 0, 3, 0);
        step('h0000, 1, 0, 1, 3, 'h20);  step('h0000, 1, 0, 0, 0, 0);
        step('h0000, 1, 0, 1, 3, 'h00);  step('h07FF, 1, 0, 0, 0, 0);
        step('h0800, 1, 0, 0, 0, 0);
        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 'hFFFF), ($urandom_range(0, 3) == 0),
                 $urandom_range(0, 3), ($urandom_range(0, 4) == 0),
                 $urandom_range(0, 3), $urandom_range(0, 255));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule